// File: doc/BRIEF.md
# Multi-Context Pipeline Stage Register

This block is a pipeline stage register for a multithreaded pipeline that changes threads when an event occurs. One thread's contents sit in the active register and drive the downstream stage. Every other thread can keep its stage contents in a private parking slot. In normal operation the block behaves as a plain pipeline register: each cycle it captures the upstream data and valid bit.

A thread switch request names an outgoing thread and an incoming thread. In that same clock edge the block does three things. It copies the active contents into the outgoing thread's slot. It loads the incoming thread's parked contents into the active register. It frees the incoming thread's slot. The stage is therefore never flushed, and a resumed thread continues without refilling the pipeline. The scheduler that decides when to switch, for example on a long-latency miss, sits outside this block.

Control is decoded into four operations: `OP_PASS`, `OP_HOLD`, `OP_SWAP` and `OP_KEEP`.

- `OP_HOLD` wins whenever stall is high.
- `OP_SWAP` is selected for a switch request with differing thread IDs.
- `OP_KEEP` is selected for a switch request with equal thread IDs.
- `OP_PASS` is selected otherwise.

Each slot runs a two-state machine with the states `SLOT_EMPTY` and `SLOT_PARKED`. Its transitions are:

- park: `SLOT_EMPTY` → `SLOT_PARKED`, on a save.
- repark: `SLOT_PARKED` → `SLOT_PARKED`, on a save that overwrites the slot.
- resume: `SLOT_PARKED` → `SLOT_EMPTY`, on a restore.
- idle: no change when neither a save nor a restore occurs.

Top module: `ctx_pipe_reg`

## Requirements
- R1: While reset is asserted and after its release, `out_valid` is 0, `out_data` is 0 and every bit of `slot_used` is 0.
- R2: With `stall` low and `sw_req` low, `out_data`/`out_valid` equal the `in_data`/`in_valid` values present at the previous rising edge.
- R3: With `stall` high, `out_data`, `out_valid` and `slot_used` keep their values across the edge, whatever `sw_req`, the IDs and the upstream inputs are.
- R4: On a switch with `sw_out_id` ≠ `sw_in_id` and `stall` low, the active data and valid bit are stored in slot `sw_out_id`, and `slot_used[sw_out_id]` becomes 1. Bit i of `slot_used` belongs to thread ID i.
- R5: On the same switch, if `slot_used[sw_in_id]` was 1, the parked data and valid bit of that slot appear on `out_data`/`out_valid` after that edge, and `slot_used[sw_in_id]` becomes 0.
- R6: On the same switch, if `slot_used[sw_in_id]` was 0, the output after the edge is a bubble: `out_valid` = 0 and `out_data` = 0.
- R7: On a switch with `sw_out_id` = `sw_in_id` and `stall` low, `out_data`, `out_valid` and `slot_used` keep their values.
- R8: The upstream `in_data`/`in_valid` present on a switch edge are discarded. They are never captured into the active register or into any slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_data | input | DATA_W | Stage data from upstream |
| in_valid | input | 1 | Upstream data valid |
| stall | input | 1 | Freeze active register and all slots |
| sw_req | input | 1 | Thread switch request |
| sw_out_id | input | ID_W | Thread leaving the stage |
| sw_in_id | input | ID_W | Thread resuming in the stage |
| out_data | output | DATA_W | Active stage data to downstream |
| out_valid | output | 1 | Active stage valid |
| slot_used | output | N_CTX | Per-thread parked flag |

## Verification
The hardest situations to reach from the ports are the ones that depend on a slot's history. One example is restoring a slot that holds a parked bubble, which is different from restoring a slot that was never written. Another is overwriting a slot that is already parked. Both need a specific sequence of earlier switches, with chosen valid bits, before the switch under test.

The stimulus first runs a directed sweep over every ordered pair of thread IDs, with fresh data between switches. It then runs long random sequences that mix passes, stalls and switches, including stalls and equal-ID requests, with invalid data injected. A per-thread model in the bench predicts each output and each slot flag.

// File: rtl/ctx_pkg.sv
package ctx_pkg;

    typedef enum logic [1:0] {
        OP_PASS = 2'd0,
        OP_HOLD = 2'd1,
        OP_SWAP = 2'd2,
        OP_KEEP = 2'd3
    } op_e;

    typedef enum logic {
        SLOT_EMPTY  = 1'b0,
        SLOT_PARKED = 1'b1
    } slot_st_e;

endpackage

// File: rtl/ctx_ctrl.sv
module ctx_ctrl
    import ctx_pkg::*;
#(
    parameter int ID_W = 2
) (
    input  logic            stall,
    input  logic            sw_req,
    input  logic [ID_W-1:0] sw_out_id,
    input  logic [ID_W-1:0] sw_in_id,
    output op_e             op
);

    always_comb begin
        unique case ({stall, sw_req})
            2'b00:          op = OP_PASS;
            2'b01:          op = (sw_out_id == sw_in_id) ? OP_KEEP : OP_SWAP;
            2'b10, 2'b11:   op = OP_HOLD;
            default:        op = OP_HOLD;
        endcase
    end

endmodule

// File: rtl/ctx_slot.sv
module ctx_slot
    import ctx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              save_en,
    input  logic              take_en,
    input  logic [DATA_W-1:0] save_data,
    input  logic              save_valid,
    output logic [DATA_W-1:0] park_data,
    output logic              park_valid,
    output logic              used
);

    slot_st_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SLOT_EMPTY:  if (save_en) state_d = SLOT_PARKED;
            SLOT_PARKED: if (save_en) state_d = SLOT_PARKED;
                         else if (take_en) state_d = SLOT_EMPTY;
            default:     state_d = SLOT_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SLOT_EMPTY;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            park_data  <= '0;
            park_valid <= 1'b0;
        end else if (save_en) begin
            park_data  <= save_data;
            park_valid <= save_valid;
        end
    end

    always_comb used = (state_q == SLOT_PARKED);

    assert_no_save_take_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(save_en && take_en));

endmodule

// File: rtl/ctx_pipe_reg.sv
module ctx_pipe_reg
    import ctx_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int N_CTX  = 4,
    parameter int ID_W   = (N_CTX > 1) ? $clog2(N_CTX) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_valid,
    input  logic              stall,
    input  logic              sw_req,
    input  logic [ID_W-1:0]   sw_out_id,
    input  logic [ID_W-1:0]   sw_in_id,
    output logic [DATA_W-1:0] out_data,
    output logic              out_valid,
    output logic [N_CTX-1:0]  slot_used
);

    op_e               op;
    logic [DATA_W-1:0] park_data  [N_CTX];
    logic              park_valid [N_CTX];
    logic [DATA_W-1:0] act_data_q;
    logic              act_valid_q;
    logic [DATA_W-1:0] rest_data;
    logic              rest_valid;

    ctx_ctrl #(.ID_W(ID_W)) ctrl_i (
        .stall     (stall),
        .sw_req    (sw_req),
        .sw_out_id (sw_out_id),
        .sw_in_id  (sw_in_id),
        .op        (op)
    );

    for (genvar g = 0; g < N_CTX; g++) begin : g_slot
        logic save_en, take_en;
        always_comb begin
            save_en = (op == OP_SWAP) && (sw_out_id == ID_W'(g));
            take_en = (op == OP_SWAP) && (sw_in_id  == ID_W'(g));
        end
        ctx_slot #(.DATA_W(DATA_W)) slot_i (
            .clk        (clk),
            .rst_n      (rst_n),
            .save_en    (save_en),
            .take_en    (take_en),
            .save_data  (act_data_q),
            .save_valid (act_valid_q),
            .park_data  (park_data[g]),
            .park_valid (park_valid[g]),
            .used       (slot_used[g])
        );
    end

    always_comb begin
        if (slot_used[sw_in_id]) begin
            rest_data  = park_data[sw_in_id];
            rest_valid = park_valid[sw_in_id];
        end else begin
            rest_data  = '0;
            rest_valid = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_data_q  <= '0;
            act_valid_q <= 1'b0;
        end else begin
            unique case (op)
                OP_PASS: begin
                    act_data_q  <= in_data;
                    act_valid_q <= in_valid;
                end
                OP_SWAP: begin
                    act_data_q  <= rest_data;
                    act_valid_q <= rest_valid;
                end
                OP_HOLD, OP_KEEP: begin
                    act_data_q  <= act_data_q;
                    act_valid_q <= act_valid_q;
                end
                default: begin
                    act_data_q  <= act_data_q;
                    act_valid_q <= act_valid_q;
                end
            endcase
        end
    end

    always_comb begin
        out_data  = act_data_q;
        out_valid = act_valid_q;
    end

    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && out_data == '0 && slot_used == '0));

    assert_pass_through_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall && !sw_req) |=> (out_data == $past(in_data) && out_valid == $past(in_valid)));

    assert_stall_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> ($stable(out_data) && $stable(out_valid) && $stable(slot_used)));

    assert_save_marks_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall && sw_req && sw_out_id != sw_in_id) |=> slot_used[$past(sw_out_id)]);

    assert_restore_frees_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall && sw_req && sw_out_id != sw_in_id) |=> !slot_used[$past(sw_in_id)]);

    assert_empty_bubble_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall && sw_req && sw_out_id != sw_in_id && !slot_used[sw_in_id])
        |=> (!out_valid && out_data == '0));

    assert_same_id_keep_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall && sw_req && sw_out_id == sw_in_id)
        |=> ($stable(out_data) && $stable(out_valid) && $stable(slot_used)));

endmodule

// File: tb/ctx_pipe_reg_tb_top.sv
`timescale 1ns/1ps
module ctx_pipe_reg_tb_top;

    localparam int DW = 8;
    localparam int NC = 4;
    localparam int IW = 2;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [DW-1:0] in_data;
    logic          in_valid;
    logic          stall;
    logic          sw_req;
    logic [IW-1:0] sw_out_id;
    logic [IW-1:0] sw_in_id;
    logic [DW-1:0] out_data;
    logic          out_valid;
    logic [NC-1:0] slot_used;

    always #2.5 clk = ~clk;

    ctx_pipe_reg #(.DATA_W(DW), .N_CTX(NC)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_valid(in_valid),
        .stall(stall), .sw_req(sw_req), .sw_out_id(sw_out_id), .sw_in_id(sw_in_id),
        .out_data(out_data), .out_valid(out_valid), .slot_used(slot_used)
    );

    logic [DW-1:0] m_d;
    logic          m_v;
    logic [DW-1:0] s_d [NC];
    logic          s_v [NC];
    logic [NC-1:0] m_used;
    int checks = 0;
    int errors = 0;
    bit done = 0;

    task automatic check_state(input string req);
        checks++;
        if (out_data !== m_d || out_valid !== m_v || slot_used !== m_used) begin
            errors++;
            $display("FAIL %s: actual data=%0h valid=%0b used=%b expected data=%0h valid=%0b used=%b",
                     req, out_data, out_valid, slot_used, m_d, m_v, m_used);
        end
    endtask

    task automatic step(input logic st, input logic sw, input logic [IW-1:0] oid,
                        input logic [IW-1:0] iid, input logic [DW-1:0] d, input logic v);
        string req;
        logic [DW-1:0] td;
        logic tv;
        @(negedge clk);
        stall = st; sw_req = sw; sw_out_id = oid; sw_in_id = iid; in_data = d; in_valid = v;
        if (st) req = "R3 stall";
        else if (sw && oid == iid) req = "R7 same id";
        else if (sw && m_used[iid]) req = "R4/R5/R8 swap restore";
        else if (sw) req = "R4/R6/R8 swap empty";
        else req = "R2 pass";
        if (st) begin
        end else if (sw) begin
            if (oid != iid) begin
                td = m_used[iid] ? s_d[iid] : '0;
                tv = m_used[iid] ? s_v[iid] : 1'b0;
                m_used[iid] = 1'b0;
                s_d[oid] = m_d; s_v[oid] = m_v; m_used[oid] = 1'b1;
                m_d = td; m_v = tv;
            end
        end else begin
            m_d = d; m_v = v;
        end
        @(posedge clk);
        #1;
        check_state(req);
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        rst_n = 0; in_data = 8'hA5; in_valid = 1; stall = 0; sw_req = 0;
        sw_out_id = 0; sw_in_id = 0;
        m_d = '0; m_v = 0; m_used = '0;
        for (int i = 0; i < NC; i++) begin s_d[i] = '0; s_v[i] = 0; end
        repeat (3) @(posedge clk);
        #1; check_state("R1 in reset");
        @(negedge clk); rst_n = 1; in_valid = 0; in_data = 0;
        #0.5; check_state("R1 after release");

        // R2: plain passing
        step(0, 0, 0, 0, 8'h11, 1);
        step(0, 0, 0, 0, 8'h22, 0);
        step(0, 0, 0, 0, 8'h33, 1);
        // R4/R6/R8: switch thread 0 -> 1, slot 1 empty, input discarded
        step(0, 1, 0, 1, 8'hEE, 1);
        step(0, 0, 0, 0, 8'h44, 1);
        // R5: back to thread 0, restores 33
        step(0, 1, 1, 0, 8'hDD, 1);
        // R3: stall with switch request and input
        step(1, 1, 0, 1, 8'h99, 1);
        step(1, 0, 0, 0, 8'h98, 0);
        // R7: same id switch
        step(0, 1, 2, 2, 8'h77, 1);
        // park a bubble then restore it (R5 with valid 0)
        step(0, 0, 0, 0, 8'h55, 0);
        step(0, 1, 0, 3, 8'h66, 1);
        step(0, 1, 3, 0, 8'h67, 1);

        // sweep all ordered id pairs
        for (int o = 0; o < NC; o++) begin
            for (int n = 0; n < NC; n++) begin
                step(0, 0, 0, 0, DW'(o * 16 + n), 1'((o + n) % 2));
                step(0, 1, IW'(o), IW'(n), 8'hFF, 1);
            end
        end

        // random mixed sequence
        for (int k = 0; k < 3000; k++) begin
            int r;
            r = $urandom_range(0, 9);
            step(r == 0, r >= 6, IW'($urandom_range(0, NC - 1)), IW'($urandom_range(0, NC - 1)),
                 DW'($urandom), 1'($urandom));
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule